// File: doc/BRIEF.md
# Coincidence-Gated Counter Bank

This block holds one wide event counter per input channel. In its plain mode each counter advances once for each rising edge on its own channel input. In coincidence mode each counter instead watches a programmable subset of all channel inputs, chosen by its own pattern register, and advances once each time every input in that subset becomes high together. Channels can be switched off through a mask register. A masked input reads as low wherever it is used, and its own counter holds still.

All inputs are treated as asynchronous. They pass through a two-stage synchroniser before any edge or pattern logic sees them, so a new edge reaches its counter on the third clock after it arrives. Software talks to the block through a narrow register port with separate write and read strobes. A counter wider than the port is read in two halves: the read of the low half returns the live low bits and also captures the whole counter into a per-channel shadow. The read of the high half returns bits from that shadow, so the two halves always come from one instant. A sticky per-channel flag records counter wrap-around and is cleared by writing ones.

Top module: `coinc_counter_bank`

## Requirements
- R1: With the control enable bit (control register bit 0) at 0, counter k advances by exactly one for each rising edge of unmasked input k, however long the input stays high. The new value is readable from the third clock after the input change.
- R2: With control bit 0 at 1, counter k advances by one each time the condition "every input selected by the ones of pattern k is high" goes from false to true. Inputs outside the pattern do not matter.
- R3: In coincidence mode, a pattern of all zeros never advances its counter, whatever the inputs do.
- R4: A 1 in mask bit k forces input k to read as low in every pattern match and in plain mode. Counter k does not change while its mask bit is 1.
- R5: When counter k steps from all ones to zero, overflow bit k becomes 1 and stays 1.
- R6: Writing the overflow register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: A read of the low word of counter k (address 2k) returns live bits [DW-1:0] and captures the full counter into shadow k. A read of the high word (address 2k+1) returns shadow k bits [2DW-1:DW], not the live counter.
- R8: After reset all counters, shadows, overflow flags, mask bits, patterns and the control bit are zero.
- R9: The register map holds pattern k at address 2N+k, control at 3N, mask at 3N+1 and overflow at 3N+2. These registers read back what was written, zero-extended. Read data is valid on the clock after the read strobe, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_in | input | NCH | Asynchronous channel inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Read data, valid the clock after rd_en |

## Verification
The embedded properties assume that NCH does not exceed DW and that CW does not exceed 2*DW. They also assume the overflow flag is only lowered through the write-one clear path. The shadow, masking and zero-pattern checks compare the register state in the top with the counter state inside the per-channel counters. The stimulus changes inputs only between clock edges and holds every level for at least three clocks, so the synchroniser never has to resolve a runt. It also reprograms mode, mask and patterns only while all inputs rest low. This keeps a configuration change from being seen as a fresh coincidence edge.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    RK_CNT_LO, RK_CNT_HI, RK_PAT, RK_CTRL, RK_MASK, RK_OVF, RK_NONE
  } reg_kind_e;

  // Decode a word address against a bank of n channels.
  function automatic reg_kind_e decode_addr(input logic [31:0] a, input logic [31:0] n);
    if (a < 2 * n)       return (a[0]) ? RK_CNT_HI : RK_CNT_LO;
    else if (a < 3 * n)  return RK_PAT;
    else if (a == 3 * n) return RK_CTRL;
    else if (a == 3 * n + 1) return RK_MASK;
    else if (a == 3 * n + 2) return RK_OVF;
    return RK_NONE;
  endfunction
endpackage

// File: rtl/cc_sync.sv
module cc_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cc_match.sv
module cc_match #(
  parameter int NCH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           sin,
  input  logic [NCH-1:0]           mask,
  input  logic                     coin,
  input  logic [NCH-1:0][NCH-1:0]  pat,
  output logic [NCH-1:0]           inc
);
  logic [NCH-1:0] live;
  logic [NCH-1:0] cond;
  logic [NCH-1:0] prev;

  assign live = sin & ~mask;

  for (genvar k = 0; k < NCH; k++) begin : g_cond
    assign cond[k] = coin ? ((pat[k] != '0) && ((live & pat[k]) == pat[k]))
                          : live[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cond;
  end

  assign inc = cond & ~prev & ~mask;
endmodule

// File: rtl/cc_counter.sv
module cc_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          ovf
);
  logic wrap;
  assign wrap = inc && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (inc) cnt <= cnt + CW'(1);
      ovf <= wrap | (ovf & ~clr);
    end
  end

  // R1: a counter moves by at most one step per clock
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)));

  // R5: wrapping from all ones raises the sticky flag
  assert_wrap_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt == '1) |=> (ovf && cnt == '0));

  // R6: a clear with no simultaneous wrap drops the flag
  assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(inc && cnt == '1)) |=> !ovf);
endmodule

// File: rtl/coinc_counter_bank.sv
module coinc_counter_bank
  import cc_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CW  = 32,
  parameter int DW  = 16,
  parameter int AW  = $clog2(3 * NCH + 3)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_in,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data
);
  localparam int CIW = $clog2(NCH);
  localparam logic [AW-1:0] PAT_BASE = AW'(2 * NCH);
  localparam logic [31:0]   NCH_V    = 32'(NCH);

  logic                     coin_q;
  logic [NCH-1:0]           mask_q;
  logic [NCH-1:0][NCH-1:0]  pat_q;
  logic [NCH-1:0][CW-1:0]   shadow_q;
  logic [NCH-1:0][CW-1:0]   cnt_w;
  logic [NCH-1:0]           ovf_w;
  logic [NCH-1:0]           sync_w;
  logic [NCH-1:0]           inc_w;
  logic [NCH-1:0]           ovf_clr;
  reg_kind_e                wkind, rkind;
  logic [CIW-1:0]           wr_pidx, rd_pidx, rd_ch;
  logic [2*DW-1:0]          live_ext, shad_ext;

  function automatic logic [DW-1:0] pad_n(input logic [NCH-1:0] v);
    pad_n = '0;
    pad_n[NCH-1:0] = v;
  endfunction

  assign wkind   = decode_addr(32'(wr_addr), NCH_V);
  assign rkind   = decode_addr(32'(rd_addr), NCH_V);
  assign wr_pidx = CIW'(wr_addr - PAT_BASE);
  assign rd_pidx = CIW'(rd_addr - PAT_BASE);
  assign rd_ch   = CIW'(rd_addr >> 1);
  assign ovf_clr = (wr_en && wkind == RK_OVF) ? wr_data[NCH-1:0] : '0;

  always_comb begin
    live_ext = '0;
    shad_ext = '0;
    live_ext[CW-1:0] = cnt_w[rd_ch];
    shad_ext[CW-1:0] = shadow_q[rd_ch];
  end

  // configuration writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coin_q <= 1'b0;
      mask_q <= '0;
      pat_q  <= '0;
    end else if (wr_en) begin
      case (wkind)
        RK_PAT:  pat_q[wr_pidx] <= wr_data[NCH-1:0];
        RK_CTRL: coin_q <= wr_data[0];
        RK_MASK: mask_q <= wr_data[NCH-1:0];
        default: ;
      endcase
    end
  end

  // reads and shadow capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      shadow_q <= '0;
    end else if (rd_en) begin
      case (rkind)
        RK_CNT_LO: begin
          rd_data         <= live_ext[DW-1:0];
          shadow_q[rd_ch] <= cnt_w[rd_ch];
        end
        RK_CNT_HI: rd_data <= shad_ext[2*DW-1:DW];
        RK_PAT:    rd_data <= pad_n(pat_q[rd_pidx]);
        RK_CTRL:   rd_data <= {{(DW-1){1'b0}}, coin_q};
        RK_MASK:   rd_data <= pad_n(mask_q);
        RK_OVF:    rd_data <= pad_n(ovf_w);
        default:   rd_data <= '0;
      endcase
    end
  end

  cc_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(chan_in), .q(sync_w)
  );

  cc_match #(.NCH(NCH)) u_match (
    .clk(clk), .rst_n(rst_n), .sin(sync_w), .mask(mask_q),
    .coin(coin_q), .pat(pat_q), .inc(inc_w)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    cc_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_w[k]), .clr(ovf_clr[k]),
      .cnt(cnt_w[k]), .ovf(ovf_w[k])
    );

    // R3: an empty pattern in coincidence mode holds its counter
    assert_zero_pat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (coin_q && pat_q[k] == '0) |=> $stable(cnt_w[k]));

    // R4: a masked channel's counter holds
    assert_masked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[k] |=> $stable(cnt_w[k]));

    // R7: a low-word read captures the whole counter into its shadow
    assert_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rkind == RK_CNT_LO && rd_ch == CIW'(k))
        |=> shadow_q[k] == $past(cnt_w[k]));
  end
endmodule

// File: tb/coinc_counter_bank_test.sv
module coinc_counter_bank_test;
  localparam int CLK_P = 10;
  localparam int WD    = 20000;

  typedef struct packed {
    logic        coin;
    logic [15:0] mask;
    logic [15:0] pat0;
    logic [15:0] stim;
    logic [1:0]  d0;
    logic [1:0]  d1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0000, 16'h0000, 16'h0001, 2'd1, 2'd0},
    '{1'b0, 16'h0000, 16'h0000, 16'h0003, 2'd1, 2'd1},
    '{1'b0, 16'h0001, 16'h0000, 16'h0003, 2'd0, 2'd1},
    '{1'b0, 16'h0000, 16'h0000, 16'h0002, 2'd0, 2'd1},
    '{1'b1, 16'h0000, 16'h0005, 16'h0005, 2'd1, 2'd0},
    '{1'b1, 16'h0000, 16'h0005, 16'h0004, 2'd0, 2'd0},
    '{1'b1, 16'h0000, 16'h0005, 16'h0007, 2'd1, 2'd1},
    '{1'b1, 16'h0004, 16'h0005, 16'h0007, 2'd0, 2'd0},
    '{1'b1, 16'h0001, 16'h0006, 16'h0006, 2'd0, 2'd1},
    '{1'b1, 16'h0000, 16'h0000, 16'hFFFF, 2'd0, 2'd1},
    '{1'b1, 16'h0000, 16'h0000, 16'h0000, 2'd0, 2'd0},
    '{1'b1, 16'h0000, 16'h0002, 16'h0006, 2'd1, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_vec = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [5:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        wr_en_s = 0, rd_en_s = 0;
  logic [3:0]  wr_addr_s = '0, rd_addr_s = '0;
  logic [1:0]  wr_data_s = '0;
  logic [1:0]  rd_data_s;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  coinc_counter_bank uut (
    .clk(clk), .rst_n(rst_n), .chan_in(in_vec),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // narrow variant: 2 channels, 4-bit counters, 2-bit port
  coinc_counter_bank #(.NCH(2), .CW(4), .DW(2)) uut_small (
    .clk(clk), .rst_n(rst_n), .chan_in(in_vec[1:0]),
    .wr_en(wr_en_s), .wr_addr(wr_addr_s), .wr_data(wr_data_s),
    .rd_en(rd_en_s), .rd_addr(rd_addr_s), .rd_data(rd_data_s)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_big(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 6'(a); wr_data = 16'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_big(input int a, output int d);
    @(negedge clk); rd_en = 1; rd_addr = 6'(a);
    @(negedge clk); rd_en = 0; d = int'(rd_data);
  endtask

  task automatic wr_small(input int a, input int d);
    @(negedge clk); wr_en_s = 1; wr_addr_s = 4'(a); wr_data_s = 2'(d);
    @(negedge clk); wr_en_s = 0;
  endtask

  task automatic rd_small(input int a, output int d);
    @(negedge clk); rd_en_s = 1; rd_addr_s = 4'(a);
    @(negedge clk); rd_en_s = 0; d = int'(rd_data_s);
  endtask

  task automatic big_count(input int ch, output int v);
    int lo, hi;
    rd_big(2 * ch, lo);
    rd_big(2 * ch + 1, hi);
    v = hi * 65536 + lo;
  endtask

  task automatic pulse(input logic [15:0] s, input int times);
    for (int i = 0; i < times; i++) begin
      @(negedge clk); in_vec = s;
      repeat (3) @(negedge clk);
      in_vec = '0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v, b0, b1, a0, a1;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R8: reset state
    rd_big(0, v);  check("R8 cnt0 lo", v, 0);
    rd_big(1, v);  check("R8 cnt0 hi", v, 0);
    rd_big(48, v); check("R8 ctrl", v, 0);
    rd_big(49, v); check("R8 mask", v, 0);
    rd_big(50, v); check("R8 ovf", v, 0);
    rd_big(32, v); check("R8 pat0", v, 0);

    // R9: register readback and unmapped address
    wr_big(32, 16'hA5A5); rd_big(32, v); check("R9 pat0", v, 16'hA5A5);
    wr_big(48, 1); rd_big(48, v); check("R9 ctrl", v, 1);
    wr_big(48, 0);
    wr_big(32, 0);
    wr_big(33, 16'h0006); rd_big(33, v); check("R9 pat1", v, 16'h0006);
    rd_big(60, v); check("R9 unmapped", v, 0);

    // R7: shadow coherence on the narrow variant
    pulse(16'h0001, 3);
    rd_small(0, v); check("R7 lo live", v, 3);
    pulse(16'h0001, 1);
    rd_small(1, v); check("R7 hi from shadow", v, 0);
    rd_small(0, v); check("R7 lo after step", v, 0);
    rd_small(1, v); check("R7 hi new shadow", v, 1);

    // R5 / R6: wrap flag on the narrow variant (count is 4)
    pulse(16'h0001, 11);
    rd_small(8, v); check("R5 no flag at 15", v, 0);
    pulse(16'h0001, 1);
    rd_small(0, v); check("R5 wrapped to 0", v, 0);
    rd_small(8, v); check("R5 flag set", v, 1);
    wr_small(8, 0); rd_small(8, v); check("R6 write 0 keeps", v, 1);
    wr_small(8, 1); rd_small(8, v); check("R6 write 1 clears", v, 0);

    // vector table: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].mask != 0) tag = "R4";
      else if (VECS[i].coin && VECS[i].pat0 == 0) tag = "R3";
      else if (VECS[i].coin) tag = "R2";
      else tag = "R1";
      wr_big(48, int'(VECS[i].coin));
      wr_big(49, int'(VECS[i].mask));
      wr_big(32, int'(VECS[i].pat0));
      big_count(0, b0);
      big_count(1, b1);
      pulse(VECS[i].stim, 1);
      big_count(0, a0);
      big_count(1, a1);
      check($sformatf("%s row %0d ch0", tag, i), a0 - b0, int'(VECS[i].d0));
      check($sformatf("%s row %0d ch1", tag, i), a1 - b1, int'(VECS[i].d1));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule